// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the privileged-state bookkeeping that a RISC core needs when it takes an exception. For one cycle the pipeline presents a request with an exception kind and its context: the faulting PC, whether the instruction sat in a branch delay slot, whether the access was a store, the faulting virtual address, the current address-space identifier and a coprocessor number. On the next clock edge the controller updates its status, cause, exception-PC, bad-address, TLB entry-high, page-table context and shadow-set control registers. It also presents the handler address and the two sequential fetch addresses that follow it.

A separate reset-entry request loads the boot address and marks the floating-point unit usable. A small write port lets setup code load the base vector, the mode bits and the shadow-set numbers. A combinational read port returns any register, so the state can be checked at the block's edge. Pipeline flush, TLB lookup and the return-from-exception path belong to neighbouring blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request kinds on `req_kind` are: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 syscall, 6 breakpoint, 7 reserved instruction, 8 coprocessor unusable, 9 overflow, 10 trap. On entry, the cause register bits [4:0] take the code: interrupt 0x0, TLB modified 0x1, refill/invalid 0x2 on load and 0x3 on store, address error 0x4 on load and 0x5 on store, syscall 0x8, breakpoint 0x9, reserved instruction 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD.
- R2: The status register holds EXL in bit 0, BEV in bit 1 and CU1 in bit 2, and reads zero elsewhere. Every exception entry sets EXL, including when EXL is already set.
- R3: The shadow-set register holds the current set in [3:0], the exception set in [7:4] and the previous set in [11:8]. Only when EXL and BEV are both clear before entry, previous takes current and current takes exception. Otherwise the register is unchanged.
- R4: When the delay-slot flag is set, the exception PC takes the PC minus 4 and cause bit 8 (BD) is set. Otherwise it takes the PC and BD is cleared.
- R5: Cause bits [7:6] (CE) take the coprocessor number on a coprocessor-unusable entry and are cleared on every other entry.
- R6: The handler address is the base vector (bits [31:12], low 12 bits read zero) plus 0x180, with three exceptions. A TLB refill with EXL clear before entry uses offset 0x000. An interrupt with cause bit 5 (IV) set uses offset 0x200. An overflow with BEV set goes to 0xBFC00200.
- R7: One cycle after an accepted request, `redirect_valid` is high for one cycle with `redirect_pc` at the handler and `redirect_npc`/`redirect_nnpc` at handler+4 and handler+8. All register updates become visible in that same cycle.
- R8: TLB modified, refill and invalid entries load the bad-address register with the faulting address. They load entry-high with VPN2 (address bits [31:13]) in [31:13] and the ASID in [7:0], and load the context register's bad-VPN2 field [22:4] with address bits [31:13].
- R9: An address-error entry loads the bad-address register and leaves entry-high and context unchanged. All other kinds leave all three unchanged.
- R10: A reset entry sets the handler to 0xBFC00000 and sets CU1, and changes no other register. It wins over an exception request in the same cycle.
- R11: A request made while `redirect_valid` is high is ignored, and a request with a kind above 10 is ignored.
- R12: Read select codes are 0 status, 1 cause, 2 exception PC, 3 bad address, 4 entry-high, 5 context, 6 shadow sets, 7 base vector. A write changes status bits [2:0], cause IV, shadow-set bits [11:0], base bits [31:12] or context bits [31:23], and is ignored for select codes 2, 3 and 4. A write in a cycle that accepts an entry is dropped.
- R13: After reset, status reads 0x2 (BEV set), the base vector reads 0x80000000, all other registers read zero, and `redirect_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_entry | input | 1 | Reset-entry request |
| req_valid | input | 1 | Exception request, one cycle |
| req_kind | input | 4 | Exception kind |
| req_store | input | 1 | Faulting access was a store |
| req_dslot | input | 1 | Faulting instruction is in a delay slot |
| req_pc | input | 32 | PC of the faulting instruction |
| req_va | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_cop | input | 2 | Coprocessor number for coprocessor-unusable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Register read data |
| redirect_valid | output | 1 | Handler fetch addresses are valid |
| redirect_pc | output | 32 | Handler address |
| redirect_npc | output | 32 | Handler address + 4 |
| redirect_nnpc | output | 32 | Handler address + 8 |

## Verification
The assertions assume that a request input is held for a single cycle. They also assume that the base vector only moves through the write port, so that the handler's upper bits can be traced back to the base one cycle earlier. Beyond that, the inputs may take any value. The stimulus randomises kinds, delay-slot and store flags, addresses and mode bits, and keeps `req_pc` word aligned. It drops each request after one cycle, except in the directed test that holds a request into the busy cycle on purpose.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int ADDR_W     = 32;
    localparam int ASID_W     = 8;
    localparam int SET_W      = 4;
    localparam int COP_W      = 2;
    localparam int CODE_W     = 5;
    localparam int PAGE_SH    = 13;
    localparam int VPN_W      = ADDR_W - PAGE_SH;
    localparam int EHI_GAP_W  = PAGE_SH - ASID_W;
    localparam int CTX_LO_W   = 4;
    localparam int PTE_W      = ADDR_W - VPN_W - CTX_LO_W;
    localparam int VEC_SH     = 12;
    localparam int BASE_W     = ADDR_W - VEC_SH;
    localparam int INSN_BYTES = 4;
    localparam int FETCH_N    = 3;
    localparam int KIND_MAX   = 10;

    localparam logic [ADDR_W-1:0] RESET_VEC    = 32'hBFC0_0000;
    localparam logic [ADDR_W-1:0] BOOT_OVF_VEC = 32'hBFC0_0200;
    localparam logic [BASE_W-1:0] BASE_RESET   = 20'h80000;
    localparam logic [VEC_SH-1:0] OFS_GENERAL  = 12'h180;
    localparam logic [VEC_SH-1:0] OFS_REFILL   = 12'h000;
    localparam logic [VEC_SH-1:0] OFS_IRQ      = 12'h200;

    typedef enum logic [3:0] {
        EK_INT       = 4'd0,
        EK_TLB_MOD   = 4'd1,
        EK_TLB_REFIL = 4'd2,
        EK_TLB_INVAL = 4'd3,
        EK_ADDR_ERR  = 4'd4,
        EK_SYSCALL   = 4'd5,
        EK_BREAK     = 4'd6,
        EK_RESV      = 4'd7,
        EK_COP_UNUSE = 4'd8,
        EK_OVERFLOW  = 4'd9,
        EK_TRAP      = 4'd10
    } exc_kind_e;

    typedef enum logic [2:0] {
        RS_STATUS  = 3'd0,
        RS_CAUSE   = 3'd1,
        RS_EPC     = 3'd2,
        RS_BADVA   = 3'd3,
        RS_ENTRYHI = 3'd4,
        RS_CONTEXT = 3'd5,
        RS_SRSCTL  = 3'd6,
        RS_EBASE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cu1;
        logic bev;
        logic exl;
    } status_t;

    typedef struct packed {
        logic              bd;
        logic [COP_W-1:0]  ce;
        logic              iv;
        logic [CODE_W-1:0] code;
    } cause_t;

    typedef struct packed {
        logic [SET_W-1:0] pss;
        logic [SET_W-1:0] ess;
        logic [SET_W-1:0] css;
    } srs_t;

    typedef struct packed {
        logic              is_reset;
        exc_kind_e         kind;
        logic              store;
        logic              dslot;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] va;
        logic [ASID_W-1:0] asid;
        logic [COP_W-1:0]  cop;
    } entry_req_t;

    function automatic logic kind_known(input logic [3:0] k);
        return k <= 4'(KIND_MAX);
    endfunction

    function automatic logic is_tlb(input exc_kind_e k);
        return (k == EK_TLB_MOD) || (k == EK_TLB_REFIL) || (k == EK_TLB_INVAL);
    endfunction

    function automatic logic [CODE_W-1:0] cause_code(input exc_kind_e k, input logic st);
        case (k)
            EK_INT:       return 5'h00;
            EK_TLB_MOD:   return 5'h01;
            EK_TLB_REFIL,
            EK_TLB_INVAL: return st ? 5'h03 : 5'h02;
            EK_ADDR_ERR:  return st ? 5'h05 : 5'h04;
            EK_SYSCALL:   return 5'h08;
            EK_BREAK:     return 5'h09;
            EK_RESV:      return 5'h0A;
            EK_COP_UNUSE: return 5'h0B;
            EK_OVERFLOW:  return 5'h0C;
            EK_TRAP:      return 5'h0D;
            default:      return 5'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
(
    input  logic              is_reset_i,
    input  exc_kind_e         kind_i,
    input  logic              old_exl_i,
    input  logic              bev_i,
    input  logic              iv_i,
    input  logic [BASE_W-1:0] ebase_i,
    output logic [ADDR_W-1:0] fetch_o [FETCH_N]
);
    logic [VEC_SH-1:0] ofs;
    logic [ADDR_W-1:0] base;

    always_comb begin
        ofs = OFS_GENERAL;
        if (kind_i == EK_TLB_REFIL && !old_exl_i) begin
            ofs = OFS_REFILL;
        end else if (kind_i == EK_INT && iv_i) begin
            ofs = OFS_IRQ;
        end
        base = {ebase_i, ofs};
        if (is_reset_i) begin
            base = RESET_VEC;
        end else if (kind_i == EK_OVERFLOW && bev_i) begin
            base = BOOT_OVF_VEC;
        end
    end

    for (genvar i = 0; i < FETCH_N; i++) begin : g_fetch
        assign fetch_o[i] = base + ADDR_W'(i * INSN_BYTES);
    end

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  entry_req_t        req_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [2:0]        rd_sel_i,
    output logic [ADDR_W-1:0] rd_data_o,
    output logic              exl_o,
    output logic              bev_o,
    output logic              iv_o,
    output logic [BASE_W-1:0] ebase_o
);
    status_t           status_q;
    cause_t            cause_q;
    srs_t              srs_q;
    logic [ADDR_W-1:0] epc_q;
    logic [ADDR_W-1:0] badva_q;
    logic [VPN_W-1:0]  ehi_vpn2_q;
    logic [ASID_W-1:0] ehi_asid_q;
    logic [PTE_W-1:0]  ctx_pte_q;
    logic [VPN_W-1:0]  ctx_vpn2_q;
    logic [BASE_W-1:0] ebase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q   <= '{cu1: 1'b0, bev: 1'b1, exl: 1'b0};
            cause_q    <= '0;
            srs_q      <= '0;
            epc_q      <= '0;
            badva_q    <= '0;
            ehi_vpn2_q <= '0;
            ehi_asid_q <= '0;
            ctx_pte_q  <= '0;
            ctx_vpn2_q <= '0;
            ebase_q    <= BASE_RESET;
        end else if (take_i) begin
            if (req_i.is_reset) begin
                status_q.cu1 <= 1'b1;
            end else begin
                status_q.exl <= 1'b1;
                if (!status_q.exl && !status_q.bev) begin
                    srs_q.pss <= srs_q.css;
                    srs_q.css <= srs_q.ess;
                end
                epc_q        <= req_i.dslot ? req_i.pc - ADDR_W'(INSN_BYTES) : req_i.pc;
                cause_q.code <= cause_code(req_i.kind, req_i.store);
                cause_q.bd   <= req_i.dslot;
                cause_q.ce   <= (req_i.kind == EK_COP_UNUSE) ? req_i.cop : '0;
                if (is_tlb(req_i.kind) || req_i.kind == EK_ADDR_ERR) begin
                    badva_q <= req_i.va;
                end
                if (is_tlb(req_i.kind)) begin
                    ehi_vpn2_q <= req_i.va[ADDR_W-1:PAGE_SH];
                    ehi_asid_q <= req_i.asid;
                    ctx_vpn2_q <= req_i.va[ADDR_W-1:PAGE_SH];
                end
            end
        end else if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                RS_STATUS:  status_q   <= wr_data_i[2:0];
                RS_CAUSE:   cause_q.iv <= wr_data_i[CODE_W];
                RS_SRSCTL:  srs_q      <= wr_data_i[3*SET_W-1:0];
                RS_CONTEXT: ctx_pte_q  <= wr_data_i[ADDR_W-1:ADDR_W-PTE_W];
                RS_EBASE:   ebase_q    <= wr_data_i[ADDR_W-1:VEC_SH];
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            RS_STATUS:  rd_data_o = {{(ADDR_W-3){1'b0}}, status_q};
            RS_CAUSE:   rd_data_o = {{(ADDR_W-$bits(cause_t)){1'b0}}, cause_q};
            RS_EPC:     rd_data_o = epc_q;
            RS_BADVA:   rd_data_o = badva_q;
            RS_ENTRYHI: rd_data_o = {ehi_vpn2_q, {EHI_GAP_W{1'b0}}, ehi_asid_q};
            RS_CONTEXT: rd_data_o = {ctx_pte_q, ctx_vpn2_q, {CTX_LO_W{1'b0}}};
            RS_SRSCTL:  rd_data_o = {{(ADDR_W-$bits(srs_t)){1'b0}}, srs_q};
            RS_EBASE:   rd_data_o = {ebase_q, {VEC_SH{1'b0}}};
            default:    rd_data_o = '0;
        endcase
    end

    assign exl_o   = status_q.exl;
    assign bev_o   = status_q.bev;
    assign iv_o    = cause_q.iv;
    assign ebase_o = ebase_q;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_entry,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              req_store,
    input  logic              req_dslot,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [COP_W-1:0]  req_cop,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] redirect_npc,
    output logic [ADDR_W-1:0] redirect_nnpc
);
    entry_req_t        req;
    logic              take;
    logic              cur_exl;
    logic              cur_bev;
    logic              cur_iv;
    logic [BASE_W-1:0] cur_ebase;
    logic [ADDR_W-1:0] fetch [FETCH_N];

    always_comb begin
        req.is_reset = rst_entry;
        req.kind     = exc_kind_e'(req_kind);
        req.store    = req_store;
        req.dslot    = req_dslot;
        req.pc       = req_pc;
        req.va       = req_va;
        req.asid     = req_asid;
        req.cop      = req_cop;
    end

    assign take = !redirect_valid && (rst_entry || (req_valid && kind_known(req_kind)));

    exc_csr_file u_csr (
        .clk       (clk),
        .rst       (rst),
        .take_i    (take),
        .req_i     (req),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .exl_o     (cur_exl),
        .bev_o     (cur_bev),
        .iv_o      (cur_iv),
        .ebase_o   (cur_ebase)
    );

    exc_vector_calc u_vec (
        .is_reset_i (rst_entry),
        .kind_i     (req.kind),
        .old_exl_i  (cur_exl),
        .bev_i      (cur_bev),
        .iv_i       (cur_iv),
        .ebase_i    (cur_ebase),
        .fetch_o    (fetch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            redirect_npc   <= '0;
            redirect_nnpc  <= '0;
        end else begin
            redirect_valid <= take;
            if (take) begin
                redirect_pc   <= fetch[0];
                redirect_npc  <= fetch[1];
                redirect_nnpc <= fetch[2];
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              take,
    input logic              rst_entry,
    input logic [3:0]        req_kind,
    input logic              wr_en,
    input logic              cur_exl,
    input logic              cur_bev,
    input logic [BASE_W-1:0] cur_ebase,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [ADDR_W-1:0] redirect_npc,
    input logic [ADDR_W-1:0] redirect_nnpc
);
    p_valid_after_take_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> redirect_valid);

    p_fetch_chain_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_npc - redirect_pc == 32'd4) &&
                           (redirect_nnpc - redirect_npc == 32'd4));

    p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

    p_exl_on_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !rst_entry) |=> cur_exl);

    p_reset_vector_r10: assert property (@(posedge clk) disable iff (rst)
        (take && rst_entry) |=> redirect_pc == RESET_VEC);

    p_base_vector_r6: assert property (@(posedge clk) disable iff (rst)
        (take && !rst_entry && !(req_kind == 4'd9 && cur_bev))
            |=> redirect_pc[ADDR_W-1:VEC_SH] == $past(cur_ebase));

    p_base_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || take) |=> $stable(cur_ebase));

endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .take           (take),
    .rst_entry      (rst_entry),
    .req_kind       (req_kind),
    .wr_en          (wr_en),
    .cur_exl        (cur_exl),
    .cur_bev        (cur_bev),
    .cur_ebase      (cur_ebase),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .redirect_npc   (redirect_npc),
    .redirect_nnpc  (redirect_nnpc)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_entry = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic        req_store = 1'b0;
    logic        req_dslot = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_cop = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        redirect_valid;
    logic [31:0] redirect_pc, redirect_npc, redirect_nnpc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .rst_entry(rst_entry), .req_valid(req_valid),
        .req_kind(req_kind), .req_store(req_store), .req_dslot(req_dslot),
        .req_pc(req_pc), .req_va(req_va), .req_asid(req_asid), .req_cop(req_cop),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .redirect_npc(redirect_npc), .redirect_nnpc(redirect_nnpc)
    );

    // bench-side model of the register state
    bit          m_exl, m_bev, m_cu1, m_iv, m_bd;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [31:0] m_epc, m_badva;
    logic [18:0] m_vpn2, m_ctx_vpn2;
    logic [7:0]  m_asid;
    logic [8:0]  m_pte;
    logic [3:0]  m_css, m_ess, m_pss;
    logic [19:0] m_ebase;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(input int k, input bit st);
        case (k)
            0: return 5'h0;   1: return 5'h1;
            2, 3: return st ? 5'h3 : 5'h2;
            4: return st ? 5'h5 : 5'h4;
            5: return 5'h8;   6: return 5'h9;   7: return 5'hA;
            8: return 5'hB;   9: return 5'hC;   default: return 5'hD;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int k, input bit oexl, input bit bev,
                                            input bit iv, input logic [19:0] eb);
        if (k == 9 && bev) return 32'hBFC00200;
        if (k == 2 && !oexl) return {eb, 12'h000};
        if (k == 0 && iv) return {eb, 12'h200};
        return {eb, 12'h180};
    endfunction

    task automatic model_reset();
        m_exl = 0; m_bev = 1; m_cu1 = 0; m_iv = 0; m_bd = 0; m_code = 0; m_ce = 0;
        m_epc = 0; m_badva = 0; m_vpn2 = 0; m_ctx_vpn2 = 0; m_asid = 0; m_pte = 0;
        m_css = 0; m_ess = 0; m_pss = 0; m_ebase = 20'h80000;
    endtask

    task automatic model_write(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: begin m_exl = d[0]; m_bev = d[1]; m_cu1 = d[2]; end
            3'd1: m_iv = d[5];
            3'd5: m_pte = d[31:23];
            3'd6: begin m_css = d[3:0]; m_ess = d[7:4]; m_pss = d[11:8]; end
            3'd7: m_ebase = d[31:12];
            default: ;
        endcase
    endtask

    // applies an accepted entry to the model, returns the expected handler
    task automatic model_entry(input int k, input bit st, input bit ds, input logic [31:0] pc,
                               input logic [31:0] va, input logic [7:0] asid,
                               input logic [1:0] cop, input bit re, output logic [31:0] vec);
        if (re) begin
            vec = 32'hBFC00000;
            m_cu1 = 1;
            return;
        end
        vec = exp_vec(k, m_exl, m_bev, m_iv, m_ebase);
        if (!m_exl && !m_bev) begin m_pss = m_css; m_css = m_ess; end
        m_exl = 1;
        m_epc = ds ? pc - 32'd4 : pc;
        m_bd = ds;
        m_code = exp_code(k, st);
        m_ce = (k == 8) ? cop : 2'd0;
        if (k >= 1 && k <= 4) m_badva = va;
        if (k >= 1 && k <= 3) begin m_vpn2 = va[31:13]; m_asid = asid; m_ctx_vpn2 = va[31:13]; end
    endtask

    task automatic read_all(input string t);
        logic [31:0] e [8];
        string nm [8];
        e[0] = {29'd0, m_cu1, m_bev, m_exl};
        e[1] = {23'd0, m_bd, m_ce, m_iv, m_code};
        e[2] = m_epc;
        e[3] = m_badva;
        e[4] = {m_vpn2, 5'd0, m_asid};
        e[5] = {m_pte, m_ctx_vpn2, 4'd0};
        e[6] = {20'd0, m_pss, m_ess, m_css};
        e[7] = {m_ebase, 12'd0};
        nm[0] = "R2 status"; nm[1] = "R1 cause"; nm[2] = "R4 epc"; nm[3] = "R9 badva";
        nm[4] = "R8 entryhi"; nm[5] = "R8 context"; nm[6] = "R3 srsctl"; nm[7] = "R12 ebase";
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            chk(t.len() > 0 ? {t, " ", nm[i]} : nm[i], rd_data, e[i]);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(sel, d);
    endtask

    task automatic drive_req(input int k, input bit st, input bit ds, input logic [31:0] pc,
                             input logic [31:0] va, input logic [7:0] asid,
                             input logic [1:0] cop, input bit re);
        req_valid = 1; req_kind = 4'(k); req_store = st; req_dslot = ds;
        req_pc = pc; req_va = va; req_asid = asid; req_cop = cop; rst_entry = re;
    endtask

    task automatic check_redirect(input string t, input logic [31:0] vec);
        chk({t, " R7 valid"}, {31'd0, redirect_valid}, 32'd1);
        chk({t, " R6 pc"}, redirect_pc, vec);
        chk({t, " R7 npc"}, redirect_npc, vec + 32'd4);
        chk({t, " R7 nnpc"}, redirect_nnpc, vec + 32'd8);
    endtask

    task automatic do_entry(input string t, input int k, input bit st, input bit ds,
                            input logic [31:0] pc, input logic [31:0] va,
                            input logic [7:0] asid, input logic [1:0] cop, input bit re);
        logic [31:0] vec;
        @(negedge clk);
        drive_req(k, st, ds, pc, va, asid, cop, re);
        model_entry(k, st, ds, pc, va, asid, cop, re, vec);
        @(negedge clk);
        req_valid = 0; rst_entry = 0;
        check_redirect(t, vec);
        read_all("");
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R7 watchdog act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] vec;
        void'($urandom(32'd5150));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R13 reset state
        chk("R13 valid", {31'd0, redirect_valid}, 32'd0);
        read_all("R13");

        // R3 rotation with EXL and BEV clear, then R2 EXL already set
        do_write(3'd6, 32'h0000_0052);
        do_write(3'd0, 32'h0);
        do_write(3'd7, 32'h1234_5000);
        do_entry("R3", 5, 0, 0, 32'h0000_4000, 32'h0, 8'h0, 2'd0, 0);
        do_entry("R2", 6, 0, 1, 32'h0000_5004, 32'h0, 8'h0, 2'd0, 0);

        // R6 refill with EXL clear and with EXL set; R8 TLB loads
        do_write(3'd0, 32'h0);
        do_write(3'd5, 32'hFF80_0000);
        do_entry("R8", 2, 1, 0, 32'h0000_6000, 32'hDEAD_BEEF, 8'h5A, 2'd0, 0);
        do_entry("R6", 2, 0, 0, 32'h0000_6100, 32'h1357_9BDF, 8'hA5, 2'd0, 0);

        // R6 interrupt with IV set, overflow with BEV set
        do_write(3'd1, 32'h20);
        do_write(3'd0, 32'h0);
        do_entry("R6", 0, 0, 0, 32'h0000_7000, 32'h0, 8'h0, 2'd0, 0);
        do_write(3'd0, 32'h2);
        do_entry("R6", 9, 0, 0, 32'h0000_7100, 32'h0, 8'h0, 2'd0, 0);

        // R5 coprocessor number, R9 address error keeps TLB registers
        do_entry("R5", 8, 0, 0, 32'h0000_8000, 32'h0, 8'h0, 2'd3, 0);
        do_entry("R9", 4, 1, 1, 32'h0000_8104, 32'hCAFE_0001, 8'h33, 2'd1, 0);

        // R10 reset entry wins over a simultaneous trap
        do_entry("R10", 10, 0, 0, 32'h0000_9000, 32'h0, 8'h0, 2'd0, 1);

        // R11 request during busy cycle is ignored
        @(negedge clk);
        drive_req(5, 0, 0, 32'h0000_A000, 32'h0, 8'h0, 2'd0, 0);
        model_entry(5, 0, 0, 32'h0000_A000, 32'h0, 8'h0, 2'd0, 0, vec);
        @(negedge clk);
        drive_req(3, 1, 1, 32'h0000_B000, 32'hFFFF_FFFF, 8'hFF, 2'd2, 0);
        check_redirect("R11 first", vec);
        @(negedge clk);
        req_valid = 0;
        chk("R11 busy ignored", {31'd0, redirect_valid}, 32'd0);
        read_all("R11");

        // R11 unknown kind ignored
        @(negedge clk);
        drive_req(13, 0, 0, 32'h0000_C000, 32'h0, 8'h0, 2'd0, 0);
        @(negedge clk);
        req_valid = 0;
        chk("R11 unknown kind", {31'd0, redirect_valid}, 32'd0);
        read_all("R11");

        // R12 write dropped in an entry cycle; writes to select 2 ignored
        @(negedge clk);
        drive_req(7, 0, 0, 32'h0000_D000, 32'h0, 8'h0, 2'd0, 0);
        wr_en = 1; wr_sel = 3'd7; wr_data = 32'h7777_7000;
        model_entry(7, 0, 0, 32'h0000_D000, 32'h0, 8'h0, 2'd0, 0, vec);
        @(negedge clk);
        req_valid = 0; wr_en = 0;
        check_redirect("R12", vec);
        read_all("R12");
        do_write(3'd2, 32'h1111_1111);
        read_all("R12");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int k;
            if ($urandom % 3 == 0)
                do_write(3'd0, {29'd0, 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom)});
            if ($urandom % 4 == 0) do_write(3'd1, $urandom);
            if ($urandom % 8 == 0) do_write(3'd7, $urandom);
            if ($urandom % 4 == 0) do_write(3'd6, $urandom);
            if ($urandom % 8 == 0) do_write(3'd5, $urandom);
            k = int'($urandom % 11);
            do_entry("R1", k, 1'($urandom), 1'($urandom), $urandom & 32'hFFFF_FFFC,
                     $urandom, 8'($urandom), 2'($urandom), $urandom % 16 == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule